// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog that sits on a simple register bus and counts down in two cascaded stages. The first stage runs from its preload value and, when it runs out, raises an interrupt and hands over to the second stage. If software still has not restarted the countdown when the second stage runs out, the block pulses a system reset request and sets a sticky timeout flag. The flag survives the reset request and is cleared only by the hardware reset or by software.

A key sequence guards the preload registers and the reload register. Software writes two key values to the reload address. The block then accepts exactly one write to a guarded register. A prescaler divides the system clock into a slow decrement tick, and a configuration bit selects one of two division ratios.

A separate byte-wide configuration port holds two registers. One is the configuration register, which sets the tick rate, masks the interrupt and disables the reset output. The other is a control register that holds the enable, function-select and lock bits. Once the lock bit is set, software can no longer stop the timer.

Top module: `wdog2_top`

## Requirements
- R1: After reset, `irq_o` and `rst_req_o` are 0, both preloads read 0x400, the reload register (address 0xC) reads 0 and the control register reads 0, so the timer is disabled.
- R2: Writing 0x80 and then 0x86 to address 0xC grants exactly one write to a guarded register (0x0 stage-1 preload, 0x4 stage-2 preload, 0xC reload). A second write without a new key pair is ignored.
- R3: A preload write without the key pair is ignored. A key sequence broken by any other value written to 0xC grants nothing.
- R4: A granted write to 0xC with bit 8 set restarts stage 1 from the stage-1 preload and clears the prescaler, so the first tick comes one full tick period later.
- R5: Stage 1 with preload N expires max(N,1) ticks after a restart. Its expiry sets status bit 0 (address 0x8) and raises `irq_o`. Writing 1 to status bit 0 clears it, and no key is needed.
- R6: When configuration bits 1:0 equal 11, `irq_o` stays low, but status bit 0 is still set.
- R7: Stage 2 with preload M expires M ticks after stage 1 expires. It sets bit 9 of the reload register and drives `rst_req_o` high for exactly 4 clock cycles, provided configuration bit 5 and control bit 2 are 0.
- R8: When configuration bit 5 is 1, stage-2 expiry leaves `rst_req_o` low, but bit 9 is still set.
- R9: Bit 9 of the reload register stays set until a granted write of 1 to it. A write without the key leaves it set.
- R10: Configuration bit 2 at 0 gives a tick every 2^15 clocks, and at 1 a tick every 2^5 clocks.
- R11: While control bit 1 (enable) is 0, the prescaler and the stage counters hold their values.
- R12: Writing control bit 0 (lock) as 1 forces enable to 1. After that, neither lock nor enable can be cleared by a write, and the control register keeps reading both bits as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; data appears on `bus_rdata` one cycle later |
| bus_rdata | output | 32 | Registered read data |
| cfg_sel | input | 1 | 0 selects the configuration register, 1 selects the control register |
| cfg_we | input | 1 | Write strobe of the configuration port |
| cfg_wdata | input | 8 | Configuration port write data |
| cfg_rdata | output | 8 | Combinational read-back of the selected register |
| irq_o | output | 1 | Stage-1 interrupt, a level signal |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The hardest state to reach from the ports is a countdown that has been frozen partway through a tick period and then resumed. The expiry must move later by exactly the number of disabled cycles, and nothing outside shows the prescaler. The bench turns the enable off a few cycles after a restart and turns it back on about a hundred cycles later. It records both edges through a free-running cycle count and predicts the interrupt edge from them. A broken key sequence is the other case that needs care: the bench interleaves a stray value between the two keys and then checks that the preload does not change.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;
  localparam logic [3:0] OFS_PRE1 = 4'h0;
  localparam logic [3:0] OFS_PRE2 = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;
  localparam logic [3:0] OFS_RLD  = 4'hC;

  localparam logic [31:0] KEY_FIRST  = 32'h0000_0080;
  localparam logic [31:0] KEY_SECOND = 32'h0000_0086;

  localparam int RLD_RESTART = 8;
  localparam int RLD_TOUT    = 9;
  localparam int CFG_RSTOFF  = 5;
  localparam int CFG_FAST    = 2;
  localparam int CTL_LOCK    = 0;
  localparam int CTL_EN      = 1;
  localparam int CTL_FUNC    = 2;

  typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_GRANT} ul_state_t;

  function automatic logic is_guarded(logic [3:0] a);
    return (a == OFS_PRE1) || (a == OFS_PRE2) || (a == OFS_RLD);
  endfunction

  function automatic logic last_count(logic [31:0] c);
    return c <= 32'd1;
  endfunction

  function automatic logic [31:0] tick_limit(logic fast, int fast_log, int slow_log);
    return fast ? ((32'd1 << fast_log) - 32'd1) : ((32'd1 << slow_log) - 32'd1);
  endfunction
endpackage

// File: rtl/wdog2_unlock.sv
module wdog2_unlock
  import wdog2_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic        grant_use
);
  ul_state_t st_q, st_d;
  logic rld_wr;

  assign rld_wr    = we && (addr == OFS_RLD);
  assign grant_use = we && is_guarded(addr) && (st_q == UL_GRANT);

  always_comb begin
    st_d = st_q;
    case (st_q)
      UL_IDLE:  if (rld_wr && wdata == KEY_FIRST) st_d = UL_ARMED;
      UL_ARMED: if (rld_wr) st_d = (wdata == KEY_SECOND) ? UL_GRANT : UL_IDLE;
      UL_GRANT: if (grant_use) st_d = UL_IDLE;
      default:  st_d = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_use |=> (st_q != UL_GRANT));
  // R3
  broken_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == UL_ARMED && rld_wr && wdata != KEY_SECOND) |=> (st_q == UL_IDLE));
endmodule

// File: rtl/wdog2_prescale.sv
module wdog2_prescale
  import wdog2_pkg::*;
#(
  parameter int FAST_LOG = 5,
  parameter int SLOW_LOG = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  input  logic clr,
  output logic tick
);
  logic [SLOW_LOG-1:0] cnt_q;

  assign tick = run && (32'(cnt_q) >= tick_limit(fast, FAST_LOG, SLOW_LOG));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else if (run)  cnt_q <= cnt_q + 1'b1;

  // R11
  psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog2_stages.sv
module wdog2_stages
  import wdog2_pkg::*;
#(
  parameter int               PRE_W   = 20,
  parameter logic [PRE_W-1:0] PRE_RST = 20'h400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  output logic             s1_expire,
  output logic             s2_expire
);
  logic             in_s2_q;
  logic [PRE_W-1:0] cnt_q;
  logic             done;

  assign done      = tick && last_count(32'(cnt_q));
  assign s1_expire = done && !in_s2_q;
  assign s2_expire = done && in_s2_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_s2_q <= 1'b0;
      cnt_q   <= PRE_RST;
    end else if (restart) begin
      in_s2_q <= 1'b0;
      cnt_q   <= pre1;
    end else if (s1_expire) begin
      in_s2_q <= 1'b1;
      cnt_q   <= pre2;
    end else if (s2_expire) begin
      in_s2_q <= 1'b0;
      cnt_q   <= pre1;
    end else if (tick) begin
      cnt_q   <= cnt_q - 1'b1;
    end

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt_q));
  // R5
  s1_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_expire && !restart) |=> in_s2_q);
endmodule

// File: rtl/wdog2_top.sv
module wdog2_top
  import wdog2_pkg::*;
#(
  parameter int               PRE_W    = 20,
  parameter logic [PRE_W-1:0] PRE_RST  = 20'h400,
  parameter int               FAST_LOG = 5,
  parameter int               SLOW_LOG = 15,
  parameter int               RST_LEN  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  output logic [31:0] bus_rdata,
  input  logic        cfg_sel,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int RC_W = $clog2(RST_LEN + 1);

  logic [PRE_W-1:0] pre1_q, pre2_q;
  logic [7:0]       cfg_q;
  logic             lock_q, en_q, func_q;
  logic             irq_flag_q, tout_q;
  logic [RC_W-1:0]  rcnt_q;

  logic unlock_ok, tick, s1_expire, s2_expire;
  logic restart, tout_clr, stat_clr, rst_fire, ctl_wr;

  wdog2_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .grant_use(unlock_ok)
  );

  assign restart  = unlock_ok && (bus_addr == OFS_RLD) && bus_wdata[RLD_RESTART];
  assign tout_clr = unlock_ok && (bus_addr == OFS_RLD) && bus_wdata[RLD_TOUT];
  assign stat_clr = bus_we && (bus_addr == OFS_STAT) && bus_wdata[0];
  assign ctl_wr   = cfg_we && cfg_sel;

  wdog2_prescale #(.FAST_LOG(FAST_LOG), .SLOW_LOG(SLOW_LOG)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(en_q), .fast(cfg_q[CFG_FAST]),
    .clr(restart), .tick(tick)
  );

  wdog2_stages #(.PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_stg (
    .clk(clk), .rst_n(rst_n), .run(en_q), .tick(tick), .restart(restart),
    .pre1(pre1_q), .pre2(pre2_q), .s1_expire(s1_expire), .s2_expire(s2_expire)
  );

  assign rst_fire = s2_expire && !cfg_q[CFG_RSTOFF] && !func_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre1_q <= PRE_RST;
      pre2_q <= PRE_RST;
    end else if (unlock_ok) begin
      if (bus_addr == OFS_PRE1) pre1_q <= bus_wdata[PRE_W-1:0];
      if (bus_addr == OFS_PRE2) pre2_q <= bus_wdata[PRE_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      func_q <= 1'b0;
    end else begin
      if (cfg_we && !cfg_sel) cfg_q <= cfg_wdata;
      if (ctl_wr) begin
        lock_q <= lock_q | cfg_wdata[CTL_LOCK];
        en_q   <= cfg_wdata[CTL_EN] | cfg_wdata[CTL_LOCK] | lock_q;
        if (!lock_q) func_q <= cfg_wdata[CTL_FUNC];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_flag_q <= 1'b0;
      tout_q     <= 1'b0;
      rcnt_q     <= '0;
    end else begin
      if (s1_expire)     irq_flag_q <= 1'b1;
      else if (stat_clr) irq_flag_q <= 1'b0;
      if (s2_expire)     tout_q <= 1'b1;
      else if (tout_clr) tout_q <= 1'b0;
      if (rst_fire)            rcnt_q <= RC_W'(RST_LEN);
      else if (rcnt_q != '0)   rcnt_q <= rcnt_q - 1'b1;
    end

  assign irq_o     = irq_flag_q && (cfg_q[1:0] != 2'b11);
  assign rst_req_o = (rcnt_q != '0);
  assign cfg_rdata = cfg_sel ? {5'b0, func_q, en_q, lock_q} : cfg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) begin
      case (bus_addr)
        OFS_PRE1: bus_rdata <= 32'(pre1_q);
        OFS_PRE2: bus_rdata <= 32'(pre2_q);
        OFS_STAT: bus_rdata <= {31'b0, irq_flag_q};
        OFS_RLD:  bus_rdata <= 32'(tout_q) << RLD_TOUT;
        default:  bus_rdata <= '0;
      endcase
    end

  // R3
  pre_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_PRE1 && !unlock_ok) |=> $stable(pre1_q));
  // R7
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire |=> (rst_req_o && tout_q));
  // R7
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |=> rst_req_o);
  // R8
  rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_expire && cfg_q[CFG_RSTOFF] && !rst_req_o) |=> !rst_req_o);
  // R9
  tout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_q && !tout_clr) |=> tout_q);
  // R12
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && en_q));
endmodule

// File: tb/wdog2_top_tb.sv
module wdog2_top_tb;
  localparam logic [3:0] A_P1 = 4'h0, A_P2 = 4'h4, A_ST = 4'h8, A_RL = 4'hC;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic        cfg_sel = 1'b0, cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0, cfg_rdata;
  logic        irq_o, rst_req_o;

  int cyc = 0, total = 0, bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog2_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bw(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic br(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic cw(logic sel, logic [7:0] d);
    @(negedge clk); cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pw(logic [3:0] a, logic [31:0] d);
    bw(A_RL, 32'h80); bw(A_RL, 32'h86); bw(a, d);
  endtask

  task automatic reload(output int e0);
    pw(A_RL, 32'h100); e0 = cyc;
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rst_req", 32'(rst_req_o), 0);
    br(A_P1, d); chk("R1 pre1", d, 32'h400);
    br(A_P2, d); chk("R1 pre2", d, 32'h400);
    br(A_RL, d); chk("R1 reload", d, 0);
    cfg_sel = 1'b1; #1; chk("R1 control", 32'(cfg_rdata), 0);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    bw(A_P1, 32'd5); br(A_P1, d); chk("R3 no key", d, 32'h400);
    pw(A_P1, 32'd3); br(A_P1, d); chk("R2 granted", d, 32'd3);
    bw(A_P1, 32'd7); br(A_P1, d); chk("R2 one write only", d, 32'd3);
    bw(A_RL, 32'h80); bw(A_RL, 32'h55); bw(A_RL, 32'h86); bw(A_P1, 32'd9);
    br(A_P1, d); chk("R3 broken key", d, 32'd3);
    pw(A_P2, 32'd2); br(A_P2, d); chk("R2 pre2", d, 32'd2);
  endtask

  task automatic t_stages();
    int e0; logic [31:0] d;
    bw(A_ST, 1); reload(e0);
    wait_to(e0 + 95);  chk("R5 irq before", 32'(irq_o), 0);
    wait_to(e0 + 96);  chk("R5 irq at expiry", 32'(irq_o), 1);
    wait_to(e0 + 159); chk("R7 rst before", 32'(rst_req_o), 0);
    wait_to(e0 + 160); chk("R7 rst first", 32'(rst_req_o), 1);
    wait_to(e0 + 163); chk("R7 rst fourth", 32'(rst_req_o), 1);
    wait_to(e0 + 164); chk("R7 rst ended", 32'(rst_req_o), 0);
    br(A_RL, d); chk("R7 timeout flag", d, 32'h200);
    br(A_ST, d); chk("R5 status", d, 1);
    bw(A_ST, 1); chk("R5 w1c", 32'(irq_o), 0);
    bw(A_RL, 32'h200); br(A_RL, d); chk("R9 unkeyed clear", d, 32'h200);
    pw(A_RL, 32'h200); br(A_RL, d); chk("R9 keyed clear", d, 0);
  endtask

  task automatic t_restart();
    int e0, e1;
    bw(A_ST, 1); reload(e0);
    wait_to(e0 + 50); reload(e1);
    wait_to(e1 + 95); chk("R4 no early irq", 32'(irq_o), 0);
    wait_to(e1 + 96); chk("R4 irq after restart", 32'(irq_o), 1);
  endtask

  task automatic t_mask();
    int e0; logic [31:0] d;
    cw(1'b0, 8'h07); bw(A_ST, 1); reload(e0);
    wait_to(e0 + 97); chk("R6 irq masked", 32'(irq_o), 0);
    br(A_ST, d); chk("R6 flag set", d, 1);
    cw(1'b0, 8'h24); bw(A_ST, 1); reload(e0);
    wait_to(e0 + 160); chk("R8 rst off", 32'(rst_req_o), 0);
    wait_to(e0 + 162); chk("R8 rst off later", 32'(rst_req_o), 0);
    br(A_RL, d); chk("R8 flag set", d, 32'h200);
    pw(A_RL, 32'h200); cw(1'b0, 8'h04);
  endtask

  task automatic t_hold();
    int e0, ed, ee, ex;
    bw(A_ST, 1); reload(e0);
    wait_to(e0 + 5); cw(1'b1, 8'h00); ed = cyc;
    wait_to(ed + 100); cw(1'b1, 8'h02); ee = cyc;
    ex = e0 + 96 + (ee - ed);
    wait_to(ex - 1); chk("R11 held", 32'(irq_o), 0);
    wait_to(ex);     chk("R11 resumed", 32'(irq_o), 1);
  endtask

  task automatic t_slow();
    int e0;
    pw(A_P1, 32'd1); cw(1'b0, 8'h00); bw(A_ST, 1); reload(e0);
    wait_to(e0 + 32767); chk("R10 slow before", 32'(irq_o), 0);
    wait_to(e0 + 32768); chk("R10 slow tick", 32'(irq_o), 1);
    cw(1'b0, 8'h04);
  endtask

  task automatic t_lock();
    int e0;
    cw(1'b1, 8'h03); cfg_sel = 1'b1; #1;
    chk("R12 locked", 32'(cfg_rdata), 32'h3);
    cw(1'b1, 8'h00); cfg_sel = 1'b1; #1;
    chk("R12 cannot clear", 32'(cfg_rdata), 32'h3);
    bw(A_ST, 1); reload(e0);
    wait_to(e0 + 32); chk("R12 still running", 32'(irq_o), 1);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unlock();
        cw(1'b0, 8'h04); cw(1'b1, 8'h02);
        t_stages();
        t_restart();
        t_mask();
        t_hold();
        t_slow();
        t_lock();
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule